// File: doc/BRIEF.md
# Trial-Squaring Integer Square Root Unit

This unit computes the integer square root of a 16-bit unsigned operand and returns an 8-bit unsigned root. A single pulse on `start` while the unit is idle captures the operand. The unit then decides the root one bit per clock, starting at the most significant bit. In each cycle it squares the current candidate with one 8x8 multiplier and compares the square against the captured operand. If the square is larger, the trial bit is dropped from the candidate. If the square is smaller, the bit stays.

When a square matches the operand exactly, the unit finishes in that same cycle, so perfect squares whose roots have trailing zero bits complete early. In every other case it finishes after eight cycles. Completion is signalled by a one-cycle `done` pulse. The root then stays on its output until the next computation completes.

Top module: `trial_sqrt`

## Requirements
- R1: After a synchronous reset, `busy` is 0, `done` is 0 and `root` is 0.
- R2: A `start` seen while idle captures `operand` at that clock edge, and `busy` is 1 from the next cycle. Changes on `operand` after that edge do not affect the result.
- R3: `root` equals floor(sqrt(operand)) for every 16-bit operand. This includes 0 (root 0), 1 (root 1) and 0xFFFF (root 0xFF).
- R4: Latency is counted in clock cycles from the edge that captures `start` to the edge that raises `done`. For an operand r*r with r >= 1, it is 8 minus the number of trailing zero bits of r. For every other operand, including 0, it is 8.
- R5: `done` is high for exactly one cycle per computation and is never high together with `busy`. `busy` stays high on every cycle from the one after the capture up to the completion edge.
- R6: A `start` raised while `busy` is 1 is ignored. It does not change the result or the latency of the computation in progress, and it produces no further `done` pulse.
- R7: `root` changes only on the edge that raises `done`, and it holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation when idle |
| operand | input | 16 | Unsigned value to take the root of |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| root | output | 8 | floor(sqrt(operand)), held until the next completion |

## Verification
The function is exercised with the values just below, at and just above every perfect square from 0 to 255 squared. These values separate a correct keep-or-drop decision from an off-by-one one at each boundary. The exact squares also show whether the early exit fires in the predicted cycle, because their latency depends on the trailing zeros of the root.

A strided sweep across the whole 16-bit range, together with the extremes 0, 1 and 0xFFFF, covers the eight-cycle path for non-squares. Separate scenarios raise `start` during a computation and change `operand` after capture. These show that the captured operand, not the live input, decides the result.

// File: rtl/trial_sqrt.sv
module trial_sqrt #(
  parameter int W  = 16,
  parameter int RW = W / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  operand,
  output logic          busy,
  output logic          done,
  output logic [RW-1:0] root
);
  localparam logic [RW-1:0] MSB = {1'b1, {(RW-1){1'b0}}};

  logic [W-1:0]  op_q;
  logic [RW-1:0] guess, trial;
  logic [W-1:0]  square;
  logic          hit, over;
  logic [RW-1:0] kept, next_trial;

  assign square     = guess * guess;
  assign hit        = (square == op_q);
  assign over       = (square > op_q);
  assign kept       = over ? (guess ^ trial) : guess;
  assign next_trial = trial >> 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      root  <= '0;
      op_q  <= '0;
      guess <= '0;
      trial <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          op_q  <= operand;
          guess <= MSB;
          trial <= MSB;
          busy  <= 1'b1;
        end
      end else if (hit) begin
        root <= guess;
        done <= 1'b1;
        busy <= 1'b0;
      end else if (next_trial == '0) begin
        root <= kept;
        done <= 1'b1;
        busy <= 1'b0;
      end else begin
        guess <= kept | next_trial;
        trial <= next_trial;
      end
    end
  end
endmodule

// File: rtl/trial_sqrt_chk.sv
module trial_sqrt_chk #(
  parameter int W  = 16,
  parameter int RW = W / 2
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] root,
  input logic [W-1:0]  op_q
);
  logic [RW:0]     r_up;
  logic [2*RW+1:0] up_sq;
  logic [2*RW+1:0] lo_sq;
  logic [2*RW+1:0] op_x;

  assign r_up  = {1'b0, root} + 1'b1;
  assign up_sq = r_up * r_up;
  assign lo_sq = {2'b00, root} * {2'b00, root};
  assign op_x  = {{(2*RW+2-W){1'b0}}, op_q};

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
  // R7
  root_hold_chk: assert property (@(posedge clk) disable iff (rst) !$stable(root) |-> done);
  // R3
  root_floor_chk: assert property (@(posedge clk) disable iff (rst) done |-> (lo_sq <= op_x && up_sq > op_x));
endmodule

bind trial_sqrt trial_sqrt_chk #(.W(W), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .done(done), .root(root), .op_q(op_q)
);

// File: tb/sim_trial_sqrt.sv
module sim_trial_sqrt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] operand = '0;
  logic        busy, done;
  logic [7:0]  root;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  trial_sqrt u0 (.clk(clk), .rst(rst), .start(start), .operand(operand),
                 .busy(busy), .done(done), .root(root));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  function automatic int ref_root(input int n);
    int r = 0;
    while ((r + 1) * (r + 1) <= n) r++;
    return r;
  endfunction

  function automatic int ref_lat(input int n);
    int r = ref_root(n);
    int tz = 0;
    if (r == 0 || r * r != n) return 8;
    while (((r >> tz) & 1) == 0) tz++;
    return 8 - tz;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int op, output int r, output int cyc, output bit busy_ok);
    @(negedge clk);
    start = 1'b1;
    operand = op[15:0];
    @(negedge clk);
    start = 1'b0;
    operand = ~op[15:0];
    busy_ok = busy;
    cyc = 0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (!busy) busy_ok = 1'b0;
      if (cyc > 20) break;
    end
    r = root;
  endtask

  task automatic one(input int op, input bit chk_lat);
    int r, cyc;
    bit bok;
    run(op, r, cyc, bok);
    check(r == ref_root(op), "R3 root", r, ref_root(op));
    if (chk_lat) check(cyc == ref_lat(op), "R4 latency", cyc, ref_lat(op));
    check(bok, "R5 busy while computing", bok, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(done == 1'b0, "R1 done after reset", done, 0);
    check(root == 8'd0, "R1 root after reset", root, 0);
  endtask

  task automatic t_corners();
    int vals[8] = '{0, 1, 2, 3, 4, 16'h4000, 16'hFE01, 16'hFFFF};
    foreach (vals[i]) one(vals[i], 1'b1);
  endtask

  task automatic t_squares();
    for (int r = 0; r < 256; r++) begin
      int s = r * r;
      if (s > 0) one(s - 1, 1'b1);
      one(s, 1'b1);
      one(s + 1, 1'b1);
    end
  endtask

  task automatic t_sweep();
    for (int n = 5; n < 65536; n += 37) one(n, 1'b0);
  endtask

  task automatic t_capture();
    int r, cyc;
    bit bok;
    run(16'h0190, r, cyc, bok);
    check(r == 20, "R2 operand captured at start", r, 20);
  endtask

  task automatic t_busy_start();
    int cyc = 0;
    int extra = 0;
    @(negedge clk);
    start = 1'b1;
    operand = 16'h0002;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    cyc = 1;
    start = 1'b1;
    operand = 16'h4000;
    @(negedge clk);
    cyc = 2;
    start = 1'b0;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    check(root == 1, "R6 root after ignored start", root, 1);
    check(cyc == 8, "R6 latency after ignored start", cyc, 8);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    check(extra == 0, "R6 no second computation", extra, 0);
  endtask

  task automatic t_hold();
    int r, cyc, changed;
    bit bok;
    run(16'h0051, r, cyc, bok);
    changed = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      operand = 16'(i * 4099);
      if (root != r[7:0]) changed++;
    end
    check(changed == 0 && r == 9, "R7 root held after done", root, 9);
    @(negedge clk);
    check(done == 1'b0, "R5 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_corners();
    t_capture();
    t_busy_start();
    t_hold();
    t_squares();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule